// File: doc/BRIEF.md
# Multi-Mode Serial Transceiver

This block is a single-channel serial port with a byte-wide register interface. Depending on a two-bit mode field it frames bytes asynchronously (start bit, seven or eight data bits sent least significant bit first, an optional even or odd parity bit, one or two stop bits), or it shifts eight bits full duplex against a clock. In the clocked modes it either drives that clock itself or follows a clock driven by another device. A two-entry transmit queue and a receive queue sit between the registers and the shift logic. A receive shift register can also hold one completed byte while the queue is full.

Software writes a control byte to pick the mode, the framing options, the clock source and the two direction enables. It then writes bytes to the data address and reads received bytes back from the same address, polling a status byte for space, data and overrun. The asynchronous receiver works from a 16x oversampling tick. That tick comes from an internal divider or from rising edges on the external clock pin.

Top module: `sio_port`

## Requirements
- R1: After reset the control register (address 2) reads 0x00, the status register (address 1) reads 0x02, `txd` is 1 and `sclk_out` is 1.
- R2: Status bit 1 (transmit space) reads 1 while fewer than two bytes wait in the transmit queue and 0 once two are queued. Writes to address 0 queue bytes only while transmit is enabled.
- R3: In asynchronous modes (control bits 7:6 = 2 for 7-bit, 3 for 8-bit) each byte is sent as a 0 start bit, the data bits LSB first, a parity bit if control bit 2 is set (control bit 3 = 1 odd, 0 even), then one stop bit (control bit 4 = 0) or two (bit 4 = 1). Each bit lasts 16 oversampling ticks and the line idles at 1.
- R4: The asynchronous receiver samples each bit near its middle and delivers the byte at address 0. In 7-bit mode bit 7 of the byte reads 0.
- R5: A start bit whose line is back at 1 at its mid-point is discarded and produces no byte.
- R6: Status bit 0 reads 1 while at least one received byte is queued and 0 once all have been read from address 0.
- R7: When a frame completes while the receive queue is full and the shift register already holds a byte, the shift register takes the new byte, the queued bytes stay unchanged and status bit 2 (overrun) is set. A single held byte with a full queue does not set it.
- R8: The overrun bit stays set until software writes address 1 with bit 2 equal to 0. Writing it with bit 2 equal to 1 leaves it unchanged.
- R9: Clearing the transmit enable (control bit 0) stops transmission and empties the transmit queue. Clearing the receive enable (control bit 1) stops reception and empties the receive queue and the held byte.
- R10: In clock master mode (mode 0), `sclk_oe` is 1 and `sclk_out` pulses low then high once per bit for eight bits, only while a byte is shifting. `txd` carries the byte LSB first and `rxd` is captured on each rising edge.
- R11: In clock slave mode (mode 1), `sclk_oe` is 0. `txd` advances on each falling edge of `sclk_in` that follows a rising edge, `rxd` is captured on rising edges, and parity and stop settings have no effect.
- R12: With control bit 5 set, the asynchronous oversampling tick is taken from rising edges of `sclk_in` instead of the internal divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops receive data at address 0) |
| reg_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Output enable for `sclk_out` |

## Verification
On every cycle the checker enforces the sticky overrun flag, the condition that overrun only rises from a full receive queue, the emptying of both queues and the idle line and clock whenever a direction is disabled. Frame contents, parity sense, stop-bit count, mid-bit sampling, false-start rejection, the order of bytes kept across an overrun and the edge behaviour in both clocked modes are shown only by the bench's scenarios, which compare serial waveforms and read-back bytes against values worked out from the requirements.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int FRAME_W = 12;

    typedef enum logic [1:0] {
        MD_MST = 2'd0,
        MD_SLV = 2'd1,
        MD_A7  = 2'd2,
        MD_A8  = 2'd3
    } xmode_e;

    typedef struct packed {
        xmode_e mode;
        logic   ext_clk;
        logic   two_stop;
        logic   par_odd;
        logic   par_en;
        logic   rx_en;
        logic   tx_en;
    } ctrl_t;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;

    localparam int ST_RXNE = 0;
    localparam int ST_TXSP = 1;
    localparam int ST_OVR  = 2;

    function automatic logic par_bit(input logic [7:0] d, input logic seven, input logic odd);
        return (^(seven ? {1'b0, d[6:0]} : d)) ^ odd;
    endfunction

    function automatic logic [FRAME_W-1:0] async_frame(input logic [7:0] d, input logic seven,
                                                       input logic pe, input logic po);
        logic [FRAME_W-1:0] f;
        f    = '1;
        f[0] = 1'b0;
        if (seven) begin
            f[7:1] = d[6:0];
            if (pe) f[8] = par_bit(d, 1'b1, po);
        end else begin
            f[8:1] = d;
            if (pe) f[9] = par_bit(d, 1'b0, po);
        end
        return f;
    endfunction

    function automatic logic [3:0] async_len(input logic seven, input logic pe, input logic ts);
        return (seven ? 4'd9 : 4'd10) + {3'b0, pe} + {3'b0, ts};
    endfunction

endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  xmode_e     mode,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    input  logic       os_tick,
    input  logic       ext_rise,
    input  logic       ext_fall,
    input  logic       have_data,
    input  logic [7:0] din,
    output logic       pop,
    output logic       txd,
    output logic       sclk_out,
    output logic       mst_sample,
    output logic       busy
);
    logic [FRAME_W-1:0] sh;
    logic [3:0]         left;
    logic [3:0]         sub;
    logic               master;

    assign master     = (mode == MD_MST);
    assign pop        = en && !busy && have_data;
    assign txd        = busy ? sh[0] : 1'b1;
    assign sclk_out   = !(busy && master) || sub[3];
    assign mst_sample = busy && master && os_tick && (sub == 4'd7);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
            sub  <= '0;
        end else if (!busy) begin
            sub <= '0;
            if (have_data) begin
                busy <= 1'b1;
                if (mode[1]) begin
                    sh   <= async_frame(din, mode == MD_A7, par_en, par_odd);
                    left <= async_len(mode == MD_A7, par_en, two_stop);
                end else begin
                    sh   <= {{(FRAME_W-8){1'b1}}, din};
                    left <= 4'd8;
                end
            end
        end else if (mode == MD_SLV) begin
            if (ext_rise) begin
                if (left == 4'd1) busy <= 1'b0;
                else              sub[0] <= 1'b1;
            end else if (ext_fall && sub[0]) begin
                sub[0] <= 1'b0;
                sh     <= {1'b1, sh[FRAME_W-1:1]};
                left   <= left - 1'b1;
            end
        end else if (os_tick) begin
            sub <= sub + 1'b1;
            if (sub == 4'hF) begin
                sh   <= {1'b1, sh[FRAME_W-1:1]};
                left <= left - 1'b1;
                if (left == 4'd1) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  xmode_e     mode,
    input  logic       par_en,
    input  logic       os_tick,
    input  logic       sync_sample,
    input  logic       rxd,
    output logic       done,
    output logic [7:0] data
);
    logic       active;
    logic [3:0] sub;
    logic [3:0] bidx;
    logic [3:0] db;
    logic [2:0] slot;

    assign db   = (mode == MD_A7) ? 4'd7 : 4'd8;
    assign slot = bidx[2:0] - 3'd1;

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst || !en) begin
            active <= 1'b0;
            sub    <= '0;
            bidx   <= '0;
            data   <= '0;
        end else if (!mode[1]) begin
            if (sync_sample) begin
                data[bidx[2:0]] <= rxd;
                if (bidx == 4'd7) begin
                    bidx <= '0;
                    done <= 1'b1;
                end else begin
                    bidx <= bidx + 1'b1;
                end
            end
        end else if (!active) begin
            if (os_tick && !rxd) begin
                active <= 1'b1;
                sub    <= '0;
                bidx   <= '0;
                data   <= '0;
            end
        end else if (os_tick) begin
            sub <= sub + 1'b1;
            if (sub == 4'd7) begin
                bidx <= bidx + 1'b1;
                if (bidx == 4'd0) begin
                    if (rxd) active <= 1'b0;
                end else if (bidx <= db) begin
                    data[slot] <= rxd;
                end else if (par_en && bidx == db + 4'd1) begin
                    active <= 1'b1;
                end else begin
                    done   <= 1'b1;
                    active <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int OS_DIV   = 4,
    parameter int TX_DEPTH = 2,
    parameter int RX_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_we,
    input  logic       reg_re,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rxd,
    output logic       txd,
    input  logic       sclk_in,
    output logic       sclk_out,
    output logic       sclk_oe
);
    localparam int DW  = (OS_DIV > 1) ? $clog2(OS_DIV) : 1;
    localparam int TCW = $clog2(TX_DEPTH+1);
    localparam int RCW = $clog2(RX_DEPTH+1);

    ctrl_t          ctrl_q;
    logic           ovr_q, hold_q;
    logic [7:0]     hold_d;
    logic [1:0]     rx_s;
    logic [2:0]     ck_s;
    logic [DW-1:0]  div_q;
    logic           div_tick, ext_rise, ext_fall, os_tick, sync_sample;
    logic           tx_full, tx_empty, tx_pop, tx_push, mst_sample, tx_busy;
    logic [7:0]     tx_dout;
    logic [TCW-1:0] tx_cnt;
    logic           rx_full, rx_empty, rx_pop, rx_push, rx_done, overrun;
    logic [7:0]     rx_dout, rx_data, rx_pdata;
    logic [RCW-1:0] rx_cnt;

    assign div_tick    = (div_q == DW'(OS_DIV-1));
    assign ext_rise    = ck_s[1] && !ck_s[2];
    assign ext_fall    = !ck_s[1] && ck_s[2];
    assign os_tick     = ctrl_q.ext_clk ? ext_rise : div_tick;
    assign sync_sample = (ctrl_q.mode == MD_MST) ? mst_sample : ext_rise;
    assign sclk_oe     = (ctrl_q.mode == MD_MST);

    assign tx_push  = reg_we && (reg_addr == A_DATA) && ctrl_q.tx_en;
    assign rx_pop   = reg_re && (reg_addr == A_DATA) && !rx_empty;
    assign rx_push  = (rx_pop && hold_q) || (rx_done && !rx_full);
    assign rx_pdata = (rx_pop && hold_q) ? hold_d : rx_data;
    assign overrun  = rx_done && rx_full && hold_q && !rx_pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_s  <= '1;
            ck_s  <= '1;
            div_q <= '0;
        end else begin
            rx_s  <= {rx_s[0], rxd};
            ck_s  <= {ck_s[1:0], sclk_in};
            div_q <= div_tick ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ovr_q  <= 1'b0;
            hold_q <= 1'b0;
            hold_d <= '0;
        end else begin
            if (reg_we && reg_addr == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata);
            if (overrun) ovr_q <= 1'b1;
            else if (reg_we && reg_addr == A_STAT && !reg_wdata[ST_OVR]) ovr_q <= 1'b0;
            if (!ctrl_q.rx_en) begin
                hold_q <= 1'b0;
            end else if (rx_done && rx_full) begin
                hold_q <= 1'b1;
                hold_d <= rx_data;
            end else if (rx_pop && hold_q) begin
                hold_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            A_DATA:  reg_rdata = rx_dout;
            A_STAT:  reg_rdata = {5'b0, ovr_q, !tx_full, !rx_empty};
            A_CTRL:  reg_rdata = ctrl_q;
            default: reg_rdata = '0;
        endcase
    end

    sio_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(!ctrl_q.tx_en), .push(tx_push), .din(reg_wdata),
        .pop(tx_pop), .dout(tx_dout), .full(tx_full), .empty(tx_empty), .count(tx_cnt)
    );

    sio_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(!ctrl_q.rx_en), .push(rx_push), .din(rx_pdata),
        .pop(rx_pop), .dout(rx_dout), .full(rx_full), .empty(rx_empty), .count(rx_cnt)
    );

    sio_tx u_tx (
        .clk(clk), .rst(rst), .en(ctrl_q.tx_en), .mode(ctrl_q.mode), .par_en(ctrl_q.par_en),
        .par_odd(ctrl_q.par_odd), .two_stop(ctrl_q.two_stop), .os_tick(os_tick),
        .ext_rise(ext_rise), .ext_fall(ext_fall), .have_data(!tx_empty), .din(tx_dout),
        .pop(tx_pop), .txd(txd), .sclk_out(sclk_out), .mst_sample(mst_sample), .busy(tx_busy)
    );

    sio_rx u_rx (
        .clk(clk), .rst(rst), .en(ctrl_q.rx_en), .mode(ctrl_q.mode), .par_en(ctrl_q.par_en),
        .os_tick(os_tick), .sync_sample(sync_sample), .rxd(rx_s[1]),
        .done(rx_done), .data(rx_data)
    );
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
    parameter int RXD = 2,
    parameter int TCW = 2,
    parameter int RCW = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           tx_en,
    input logic           rx_en,
    input logic           master,
    input logic           ovr,
    input logic           wr_clr,
    input logic [TCW-1:0] tx_cnt,
    input logic [RCW-1:0] rx_cnt,
    input logic           txd,
    input logic           sclk_out
);
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr && !wr_clr) |=> ovr);                                     // R8
    AST_OVR_FROM_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> ($past(rx_cnt) == RCW'(RXD)));                  // R7
    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (tx_cnt == '0));                                    // R9
    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (rx_cnt == '0));                                    // R9
    AST_TXD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> txd);                                               // R3
    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (master && !tx_en) |=> sclk_out);                              // R10
endmodule

bind sio_port sio_port_chk #(.RXD(RX_DEPTH), .TCW(TCW), .RCW(RCW)) u_chk (
    .clk(clk), .rst(rst), .tx_en(ctrl_q.tx_en), .rx_en(ctrl_q.rx_en),
    .master(ctrl_q.mode == sio_pkg::MD_MST), .ovr(ovr_q),
    .wr_clr(reg_we && reg_addr == sio_pkg::A_STAT && !reg_wdata[sio_pkg::ST_OVR]),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .txd(txd), .sclk_out(sclk_out)
);

// File: tb/tb_sio_port.sv
module tb_sio_port;
    localparam int OSD  = 2;
    localparam int BIT  = 16 * OSD;
    localparam int BITX = 64;

    logic       clk = 0, rst = 1;
    logic       reg_we = 0, reg_re = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       rxd = 1, txd, sclk_out, sclk_oe;
    logic       ext_run = 0, ext_osc = 0, man_sclk = 1;
    logic       sclk_in;
    int         checks = 0, errs = 0;
    logic [7:0] v;

    assign sclk_in = ext_run ? ext_osc : man_sclk;

    sio_port #(.OS_DIV(OSD), .TX_DEPTH(2), .RX_DEPTH(2)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe)
    );

    always #5 clk = ~clk;
    initial forever #20 ext_osc = ~ext_osc;

    // mode[12:11] par_en[10] par_odd[9] two_stop[8] data[7:0]
    localparam logic [12:0] VEC [5] = '{
        {2'd3, 1'b1, 1'b0, 1'b0, 8'hA5},
        {2'd3, 1'b1, 1'b1, 1'b1, 8'h3C},
        {2'd2, 1'b0, 1'b0, 1'b1, 8'h81},
        {2'd2, 1'b1, 1'b1, 1'b0, 8'h7E},
        {2'd3, 1'b0, 1'b0, 1'b0, 8'h01}
    };

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_re = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_re = 0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic void exp_frame(input logic [1:0] md, input logic pe, input logic po,
                                      input logic ts, input logic [7:0] d,
                                      output logic [11:0] f, output int n);
        int db;
        db = (md == 2'd2) ? 7 : 8;
        f = '1; f[0] = 0;
        for (int i = 0; i < db; i++) f[1+i] = d[i];
        n = 1 + db;
        if (pe) begin f[n] = (^(d & ((db == 7) ? 8'h7F : 8'hFF))) ^ po; n++; end
        n = n + 1 + int'(ts);
    endfunction

    task automatic capture(input int bt, input int n, output logic [11:0] got);
        got = '1;
        @(negedge txd);
        repeat (bt/2) @(posedge clk);
        for (int i = 0; i < n; i++) begin
            #1 got[i] = txd;
            if (i < n-1) repeat (bt) @(posedge clk);
        end
    endtask

    task automatic send(input logic [7:0] d, input int db, input logic pe, input logic po);
        @(negedge clk); rxd = 0; waitc(BIT);
        for (int i = 0; i < db; i++) begin rxd = d[i]; waitc(BIT); end
        if (pe) begin rxd = (^(d & ((db == 7) ? 8'h7F : 8'hFF))) ^ po; waitc(BIT); end
        rxd = 1; waitc(2*BIT);
    endtask

    initial begin
        waitc(150000);
        errs++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [11:0] ef, gf;
        logic [7:0]  tb_b, rb;
        int          n;
        waitc(4); @(negedge clk); rst = 0;

        rd(2'd2, v); check("R1 ctrl", v, 8'h00);
        rd(2'd1, v); check("R1 status", v, 8'h02);
        check("R1 txd", txd, 1'b1);
        check("R1 sclk_out", sclk_out, 1'b1);

        // R3: table of asynchronous transmit frames
        foreach (VEC[k]) begin
            wr(2'd2, {VEC[k][12:11], 1'b0, VEC[k][8], VEC[k][9], VEC[k][10], 2'b01});
            exp_frame(VEC[k][12:11], VEC[k][10], VEC[k][9], VEC[k][8], VEC[k][7:0], ef, n);
            fork
                wr(2'd0, VEC[k][7:0]);
                capture(BIT, n, gf);
            join
            check("R3 frame", gf, ef);
            waitc(2*BIT);
            wr(2'd2, 8'h00);
        end

        // R2 transmit space, then R9 transmit flush
        wr(2'd2, 8'hC1);
        wr(2'd0, 8'h12); wr(2'd0, 8'h34);
        rd(2'd1, v); check("R2 one queued", v[1], 1'b1);
        wr(2'd0, 8'h56);
        rd(2'd1, v); check("R2 two queued", v[1], 1'b0);
        wr(2'd2, 8'hC0);
        rd(2'd1, v); check("R9 tx flush space", v[1], 1'b1);
        check("R9 tx idle line", txd, 1'b1);
        wr(2'd0, 8'h77); waitc(3*BIT);
        check("R2 write ignored when disabled", txd, 1'b1);

        // R4/R6 async receive with even parity, then 7-bit
        wr(2'd2, 8'hC6);
        send(8'hA5, 8, 1'b1, 1'b0);
        rd(2'd1, v); check("R6 not empty", v[0], 1'b1);
        rd(2'd0, v); check("R4 byte 8-bit", v, 8'hA5);
        rd(2'd1, v); check("R6 empty after read", v[0], 1'b0);
        wr(2'd2, 8'h82);
        send(8'hFF, 7, 1'b0, 1'b0);
        rd(2'd0, v); check("R4 7-bit zero extend", v, 8'h7F);

        // R5 false start
        wr(2'd2, 8'hC2);
        @(negedge clk); rxd = 0; waitc(8); rxd = 1; waitc(12*BIT);
        rd(2'd1, v); check("R5 no byte from glitch", v[0], 1'b0);
        send(8'h3C, 8, 1'b0, 1'b0);
        rd(2'd0, v); check("R5 recovers", v, 8'h3C);

        // R7 overrun, R8 sticky flag
        send(8'h11, 8, 0, 0); send(8'h22, 8, 0, 0); send(8'h33, 8, 0, 0);
        rd(2'd1, v); check("R7 held byte no overrun", v[2], 1'b0);
        send(8'h44, 8, 0, 0);
        rd(2'd1, v); check("R7 overrun set", v[2], 1'b1);
        rd(2'd0, v); check("R7 first kept", v, 8'h11);
        rd(2'd0, v); check("R7 second kept", v, 8'h22);
        rd(2'd0, v); check("R7 shift reg replaced", v, 8'h44);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check("R8 write 1 keeps", v[2], 1'b1);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R8 write 0 clears", v[2], 1'b0);

        // R9 receive flush
        send(8'h55, 8, 0, 0);
        wr(2'd2, 8'hC0);
        rd(2'd1, v); check("R9 rx flush", v[0], 1'b0);
        wr(2'd2, 8'hC2);
        rd(2'd1, v); check("R9 stays empty", v[0], 1'b0);

        // R12 external oversampling clock
        ext_run = 1;
        wr(2'd2, 8'hE1);
        exp_frame(2'd3, 0, 0, 0, 8'h96, ef, n);
        fork
            wr(2'd0, 8'h96);
            capture(BITX, n, gf);
        join
        check("R12 ext clock frame", gf, ef);
        waitc(2*BITX);
        wr(2'd2, 8'h00);
        ext_run = 0;

        // R10 clock master
        wr(2'd2, 8'h03);
        check("R10 sclk_oe", sclk_oe, 1'b1);
        check("R10 idle clock high", sclk_out, 1'b1);
        rb = 8'h5A; tb_b = '0;
        @(negedge clk); rxd = rb[0];
        wr(2'd0, 8'hC3);
        for (int i = 0; i < 8; i++) begin
            @(posedge sclk_out); #1 tb_b[i] = txd;
            if (i < 7) begin @(negedge sclk_out); #1 rxd = rb[i+1]; end
        end
        check("R10 master tx bits", tb_b, 8'hC3);
        waitc(BIT);
        check("R10 clock stops high", sclk_out, 1'b1);
        rd(2'd0, v); check("R10 master rx byte", v, 8'h5A);
        wr(2'd2, 8'h00);

        // R11 clock slave, parity and two stop bits set but ignored
        wr(2'd2, 8'h57);
        check("R11 sclk_oe", sclk_oe, 1'b0);
        wr(2'd0, 8'h69); waitc(6);
        rb = 8'hA6; tb_b = '0;
        for (int i = 0; i < 8; i++) begin
            man_sclk = 0; waitc(6);
            rxd = rb[i]; waitc(6);
            tb_b[i] = txd;
            man_sclk = 1; waitc(8);
        end
        check("R11 slave tx bits", tb_b, 8'h69);
        rd(2'd0, v); check("R11 slave rx byte", v, 8'hA6);
        check("R11 line idle after byte", txd, 1'b1);

        summary();
    end
endmodule